// File: doc/BRIEF.md
# Cartridge Bank Mapping Unit

This block is the bank controller of an 8-bit console cartridge. The CPU programs it through byte writes into the cartridge address space. From those writes it holds a bank-select index, two mode flags, eight 1 KB character slot registers, three switchable 8 KB program window registers and a mirroring flag. It turns the CPU's program address and the video unit's pattern address into wide ROM addresses, and it drives the nametable mirroring select.

Register writes arrive as a single-cycle strobe with address and data. The block accepts every write and never stalls it, so this port has no back-pressure. Address translation is purely combinational. A ROM address is the bank number held for the addressed window or slot, followed by the in-bank offset of the incoming address. The parameters give the number of 8 KB program banks and 1 KB character banks present, as powers of two. Bank numbers written by software are cut down to that many banks.

Top module: `cart_bank_mapper`

## Requirements
- R1: A write is decoded from `cpu_wr_addr & 0xF003` only. 0x8000 is the select register, 0x8001 the bank data register and 0xA000 the mirroring register. Writes to any other decoded value, including 0xC000, 0xC001, 0xE000 and 0xE001, change no mapping.
- R2: A select write takes bits 3:0 of the data as the index, bit 6 as the program rotate flag and bit 7 as the character swap flag. Bits 5:4 are ignored.
- R3: A bank data write with index 0 loads slots 0 and 1 with the value v and v+1 (the increment wraps inside the bank width). With index 1 it loads slots 2 and 3. When the swap flag is set, these become slots 4/5 and 6/7.
- R4: Indices 2, 3, 4 and 5 each load one slot: 4, 5, 6 and 7 when the swap flag is clear, and 0, 1, 2 and 3 when it is set.
- R5: Index 8 loads slot 1 and index 9 loads slot 3, whatever the swap flag holds.
- R6: With the rotate flag clear, indices 6, 7 and 15 load program windows 0x8000, 0xA000 and 0xC000. With it set, they load 0xA000, 0xC000 and 0x8000. The flag is applied when the data is written.
- R7: The 0xE000 program window always maps to the last program bank.
- R8: A mirroring write sets `mirror_horiz` to data bit 0: 1 is horizontal, 0 is vertical.
- R9: After reset, all program windows map to the last bank and slot i holds bank i. The index, both flags and `mirror_horiz` are 0.
- R10: A written bank value keeps only its low log2(bank count) bits.
- R11: A bank data write while the index is 10 to 14 changes no mapping.
- R12: `chr_rom_addr` = {slot[chr_addr[12:10]], chr_addr[9:0]} and `prg_rom_addr` = {window[prg_addr[14:13]], prg_addr[12:0]}, both combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | Register write strobe, one cycle per write |
| cpu_wr_addr | input | 16 | Register write address |
| cpu_wr_data | input | 8 | Register write data |
| prg_addr | input | 15 | CPU address bits 14:0 inside the 0x8000–0xFFFF program space |
| chr_addr | input | 13 | Video pattern address, 0x0000–0x1FFF |
| prg_rom_addr | output | log2(PRG_BANKS)+13 | Banked program ROM address |
| chr_rom_addr | output | log2(CHR_BANKS)+10 | Banked character ROM address |
| mirror_horiz | output | 1 | Nametable mirroring: 1 horizontal, 0 vertical |

## Verification
The assertions check on every cycle that the top program window stays on the last bank. They also check that select writes land in the index and both flags, that mirroring follows bit 0 of its write, and that ignored writes and unused indices leave every bank register unchanged. They check the v/v+1 pairing for index 0 and the rotated target for index 15. Only the bench scenarios show the full slot routing under both swap states, the three program targets under both rotate states, register aliasing through the address mask, truncation of oversized bank numbers, and the exact translated addresses across every slot and window.

// File: rtl/bankmap_pkg.sv
package bankmap_pkg;
  typedef enum logic [1:0] {
    WR_NONE   = 2'd0,
    WR_SELECT = 2'd1,
    WR_BANK   = 2'd2,
    WR_MIRROR = 2'd3
  } wr_kind_e;

  localparam logic [15:0] DEC_MASK = 16'hF003;
  localparam logic [15:0] A_SELECT = 16'h8000;
  localparam logic [15:0] A_BANK   = 16'h8001;
  localparam logic [15:0] A_MIRROR = 16'hA000;
endpackage

// File: rtl/bankmap_ctrl.sv
module bankmap_ctrl
  import bankmap_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_wr,
  input  logic [15:0] cpu_wr_addr,
  input  logic [7:0]  cpu_wr_data,
  output logic [3:0]  sel_idx,
  output logic        prg_mode,
  output logic        chr_inv,
  output logic        mirror_horiz,
  output logic        bank_wr
);
  wr_kind_e   kind;
  logic [15:0] dec_addr;
  logic       unused_bits;

  assign dec_addr    = cpu_wr_addr & DEC_MASK;
  assign unused_bits = ^{cpu_wr_addr[11:2], cpu_wr_data[5:4]};

  always_comb begin
    kind = WR_NONE;
    if (cpu_wr) begin
      unique case (dec_addr)
        A_SELECT: kind = WR_SELECT;
        A_BANK:   kind = WR_BANK;
        A_MIRROR: kind = WR_MIRROR;
        default:  kind = WR_NONE;
      endcase
    end
  end

  assign bank_wr = (kind == WR_BANK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_idx      <= '0;
      prg_mode     <= 1'b0;
      chr_inv      <= 1'b0;
      mirror_horiz <= 1'b0;
    end else begin
      if (kind == WR_SELECT) begin
        sel_idx  <= cpu_wr_data[3:0];
        prg_mode <= cpu_wr_data[6];
        chr_inv  <= cpu_wr_data[7];
      end
      if (kind == WR_MIRROR) mirror_horiz <= cpu_wr_data[0];
    end
  end
endmodule

// File: rtl/bankmap_chr.sv
module bankmap_chr #(
  parameter int CHR_BANKS = 128,
  localparam int CW = $clog2(CHR_BANKS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bank_wr,
  input  logic [3:0]          sel_idx,
  input  logic                chr_inv,
  input  logic [CW-1:0]       bank_val,
  input  logic [12:0]         chr_addr,
  output logic [7:0][CW-1:0]  chr_slot,
  output logic [CW+9:0]       chr_rom_addr
);
  logic [2:0] pair_base;
  logic [3:0] single_raw;
  logic [2:0] single_tgt;
  logic       is_pair, is_single;
  logic [CW-1:0] bank_next;

  assign is_pair    = (sel_idx == 4'd0) || (sel_idx == 4'd1);
  assign is_single  = (sel_idx >= 4'd2) && (sel_idx <= 4'd5);
  assign pair_base  = {chr_inv, sel_idx[0], 1'b0};
  assign single_raw = chr_inv ? (sel_idx - 4'd2) : (sel_idx + 4'd2);
  assign single_tgt = single_raw[2:0];
  assign bank_next  = bank_val + 1'b1;

  for (genvar s = 0; s < 8; s++) begin : g_slot
    localparam logic [2:0] SLOT = 3'(s);
    logic hit_pair, hit_single, hit_direct, we;
    logic [CW-1:0] wval;

    assign hit_pair   = is_pair && (SLOT[2:1] == pair_base[2:1]);
    assign hit_single = is_single && (SLOT == single_tgt);
    assign hit_direct = ((sel_idx == 4'd8) && (SLOT == 3'd1)) ||
                        ((sel_idx == 4'd9) && (SLOT == 3'd3));
    assign we         = bank_wr && (hit_pair || hit_single || hit_direct);
    assign wval       = (hit_pair && SLOT[0]) ? bank_next : bank_val;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  chr_slot[s] <= CW'(s);
      else if (we) chr_slot[s] <= wval;
    end
  end

  assign chr_rom_addr = {chr_slot[chr_addr[12:10]], chr_addr[9:0]};
endmodule

// File: rtl/bankmap_prg.sv
module bankmap_prg #(
  parameter int PRG_BANKS = 16,
  localparam int PW = $clog2(PRG_BANKS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bank_wr,
  input  logic [3:0]          sel_idx,
  input  logic                prg_mode,
  input  logic [PW-1:0]       bank_val,
  input  logic [14:0]         prg_addr,
  output logic [2:0][PW-1:0]  prg_win,
  output logic [PW+12:0]      prg_rom_addr
);
  localparam logic [PW-1:0] LAST_BANK = PW'(PRG_BANKS - 1);

  logic [1:0] dest;
  logic       dest_ok;
  logic [PW-1:0] sel_bank;

  always_comb begin
    dest_ok = 1'b1;
    unique case (sel_idx)
      4'd6:    dest = prg_mode ? 2'd1 : 2'd0;
      4'd7:    dest = prg_mode ? 2'd2 : 2'd1;
      4'd15:   dest = prg_mode ? 2'd0 : 2'd2;
      default: begin dest = 2'd0; dest_ok = 1'b0; end
    endcase
  end

  for (genvar w = 0; w < 3; w++) begin : g_win
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        prg_win[w] <= LAST_BANK;
      else if (bank_wr && dest_ok && (dest == 2'(w)))
        prg_win[w] <= bank_val;
    end
  end

  assign sel_bank     = (prg_addr[14:13] == 2'd3) ? LAST_BANK : prg_win[prg_addr[14:13]];
  assign prg_rom_addr = {sel_bank, prg_addr[12:0]};
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper #(
  parameter int PRG_BANKS = 16,
  parameter int CHR_BANKS = 128,
  localparam int PW = $clog2(PRG_BANKS),
  localparam int CW = $clog2(CHR_BANKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_wr,
  input  logic [15:0]   cpu_wr_addr,
  input  logic [7:0]    cpu_wr_data,
  input  logic [14:0]   prg_addr,
  input  logic [12:0]   chr_addr,
  output logic [PW+12:0] prg_rom_addr,
  output logic [CW+9:0]  chr_rom_addr,
  output logic          mirror_horiz
);
  logic [3:0]          sel_idx;
  logic                prg_mode, chr_inv, bank_wr;
  logic [7:0][CW-1:0]  chr_slot;
  logic [2:0][PW-1:0]  prg_win;

  bankmap_ctrl u_ctrl (
    .clk, .rst_n, .cpu_wr, .cpu_wr_addr, .cpu_wr_data,
    .sel_idx, .prg_mode, .chr_inv, .mirror_horiz, .bank_wr
  );

  bankmap_chr #(.CHR_BANKS(CHR_BANKS)) u_chr (
    .clk, .rst_n, .bank_wr, .sel_idx, .chr_inv,
    .bank_val(cpu_wr_data[CW-1:0]), .chr_addr, .chr_slot, .chr_rom_addr
  );

  bankmap_prg #(.PRG_BANKS(PRG_BANKS)) u_prg (
    .clk, .rst_n, .bank_wr, .sel_idx, .prg_mode,
    .bank_val(cpu_wr_data[PW-1:0]), .prg_addr, .prg_win, .prg_rom_addr
  );
endmodule

// File: rtl/cart_bank_mapper_chk.sv
module cart_bank_mapper_chk #(
  parameter int PRG_BANKS = 16,
  parameter int CHR_BANKS = 128,
  localparam int PW = $clog2(PRG_BANKS),
  localparam int CW = $clog2(CHR_BANKS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cpu_wr,
  input logic [15:0]         cpu_wr_addr,
  input logic [7:0]          cpu_wr_data,
  input logic [14:0]         prg_addr,
  input logic [PW+12:0]      prg_rom_addr,
  input logic                mirror_horiz,
  input logic [3:0]          sel_idx,
  input logic                prg_mode,
  input logic                chr_inv,
  input logic [7:0][CW-1:0]  chr_slot,
  input logic [2:0][PW-1:0]  prg_win
);
  logic [15:0] dec;
  logic wr_sel, wr_bank, wr_mir, wr_other;
  assign dec      = cpu_wr_addr & 16'hF003;
  assign wr_sel   = cpu_wr && dec == 16'h8000;
  assign wr_bank  = cpu_wr && dec == 16'h8001;
  assign wr_mir   = cpu_wr && dec == 16'hA000;
  assign wr_other = cpu_wr && !(dec inside {16'h8000, 16'h8001, 16'hA000});

  AST_FIXED_TOP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    prg_addr[14:13] == 2'd3 |-> prg_rom_addr[PW+12:13] == PW'(PRG_BANKS - 1)); // R7

  AST_SELECT_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel |=> sel_idx == $past(cpu_wr_data[3:0]) && prg_mode == $past(cpu_wr_data[6])
               && chr_inv == $past(cpu_wr_data[7])); // R2

  AST_MIRROR_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mir |=> mirror_horiz == $past(cpu_wr_data[0])); // R8

  AST_OTHER_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_other |=> $stable(chr_slot) && $stable(prg_win) && $stable(mirror_horiz)
                 && $stable(sel_idx)); // R1

  AST_UNUSED_INDEX_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bank && sel_idx inside {[4'd10:4'd14]} |=> $stable(chr_slot) && $stable(prg_win)); // R11

  AST_PAIR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bank && sel_idx == 4'd0 && !chr_inv |=> chr_slot[1] == CW'(chr_slot[0] + 1'b1)); // R3

  AST_ROTATED_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bank && sel_idx == 4'd15 && prg_mode |=> prg_win[0] == $past(cpu_wr_data[PW-1:0])); // R6
endmodule

bind cart_bank_mapper cart_bank_mapper_chk #(.PRG_BANKS(PRG_BANKS), .CHR_BANKS(CHR_BANKS)) u_chk (.*);

// File: tb/cart_bank_mapper_test.sv
module cart_bank_mapper_test;
  localparam int PB = 16, CB = 128, PW = 4, CW = 7;

  logic clk = 1'b0, rst_n = 1'b0, cpu_wr = 1'b0;
  logic [15:0] cpu_wr_addr = '0;
  logic [7:0]  cpu_wr_data = '0;
  logic [14:0] prg_addr = '0;
  logic [12:0] chr_addr = '0;
  logic [PW+12:0] prg_rom_addr;
  logic [CW+9:0]  chr_rom_addr;
  logic mirror_horiz;

  always #5 clk = ~clk;

  cart_bank_mapper #(.PRG_BANKS(PB), .CHR_BANKS(CB)) uut (.*);

  typedef struct { int kind; logic [31:0] exp; string req; } item_t;
  item_t q[$];
  event ev_sample;
  int n_chk = 0, n_err = 0;
  bit finished = 0;

  // reference state built from the requirements
  logic [CW-1:0] m_chr[8];
  logic [PW-1:0] m_prg[3];
  logic m_mir, m_mode, m_inv;
  logic [3:0] m_idx;

  task automatic model_reset();
    for (int s = 0; s < 8; s++) m_chr[s] = CW'(s);
    for (int w = 0; w < 3; w++) m_prg[w] = PW'(PB - 1);
    m_mir = 0; m_mode = 0; m_inv = 0; m_idx = 0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    logic [15:0] m;
    logic [CW-1:0] v;
    @(negedge clk);
    cpu_wr = 1; cpu_wr_addr = a; cpu_wr_data = d;
    @(negedge clk);
    cpu_wr = 0;
    m = a & 16'hF003;
    v = d[CW-1:0];
    if (m == 16'h8000) begin m_idx = d[3:0]; m_mode = d[6]; m_inv = d[7]; end
    else if (m == 16'hA000) m_mir = d[0];
    else if (m == 16'h8001) begin
      case (m_idx)
        4'd0, 4'd1: begin
          m_chr[{m_inv, m_idx[0], 1'b0}] = v;
          m_chr[{m_inv, m_idx[0], 1'b1}] = v + 1'b1;
        end
        4'd2, 4'd3, 4'd4, 4'd5: m_chr[m_inv ? m_idx - 2 : m_idx + 2] = v;
        4'd8: m_chr[1] = v;
        4'd9: m_chr[3] = v;
        4'd6:  m_prg[m_mode ? 1 : 0] = d[PW-1:0];
        4'd7:  m_prg[m_mode ? 2 : 1] = d[PW-1:0];
        4'd15: m_prg[m_mode ? 0 : 2] = d[PW-1:0];
        default: ;
      endcase
    end
  endtask

  task automatic probe(input int kind, input int addr, input logic [31:0] exp, input string req);
    item_t it;
    @(negedge clk);
    if (kind == 0) chr_addr = 13'(addr);
    else if (kind == 1) prg_addr = 15'(addr);
    it.kind = kind; it.exp = exp; it.req = req;
    q.push_back(it);
    -> ev_sample;
    #2;
  endtask

  initial forever begin
    item_t it;
    logic [31:0] act;
    @(ev_sample);
    #1;
    it = q.pop_front();
    act = (it.kind == 0) ? 32'(chr_rom_addr) : (it.kind == 1) ? 32'(prg_rom_addr) : 32'(mirror_horiz);
    n_chk++;
    if (act !== it.exp) begin
      n_err++;
      $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
    end
  end

  task automatic chk_all(input string req);
    for (int s = 0; s < 8; s++) begin
      int off = (s * 37 + 5) % 1024;
      probe(0, s * 1024 + off, 32'({m_chr[s], 10'(off)}), req);
    end
    for (int w = 0; w < 4; w++) begin
      int off = (w * 1999 + 3) % 8192;
      logic [PW-1:0] b = (w == 3) ? PW'(PB - 1) : m_prg[w];
      probe(1, w * 8192 + off, 32'({b, 13'(off)}), req);
    end
    probe(2, 0, 32'(m_mir), req);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk_all("R9 reset map R7 R12");
    // R3 pairs without and with swap
    wr(16'h8000, 8'h00); wr(16'h8001, 8'h20);
    wr(16'h8000, 8'h81); wr(16'h8001, 8'h30);
    chk_all("R3 pair load");
    // R4 singles both swap states
    for (int i = 2; i <= 5; i++) begin wr(16'h8000, 8'(i)); wr(16'h8001, 8'(8'h40 + i)); end
    chk_all("R4 single swap clear");
    for (int i = 2; i <= 5; i++) begin wr(16'h8000, 8'(8'h80 | i)); wr(16'h8001, 8'(8'h50 + i)); end
    chk_all("R4 single swap set");
    // R5 direct slots
    wr(16'h8000, 8'h88); wr(16'h8001, 8'h65);
    wr(16'h8000, 8'h09); wr(16'h8001, 8'h66);
    chk_all("R5 direct slots");
    // R6 program targets in both modes
    wr(16'h8000, 8'h06); wr(16'h8001, 8'h01);
    wr(16'h8000, 8'h07); wr(16'h8001, 8'h02);
    wr(16'h8000, 8'h0F); wr(16'h8001, 8'h03);
    chk_all("R6 rotate clear R7");
    wr(16'h8000, 8'h46); wr(16'h8001, 8'h05);
    wr(16'h8000, 8'h47); wr(16'h8001, 8'h06);
    wr(16'h8000, 8'h4F); wr(16'h8001, 8'h07);
    chk_all("R6 rotate set R7");
    // R2 bits 5:4 ignored: 0x36 selects index 6 with rotate clear
    wr(16'h8000, 8'h36); wr(16'h8001, 8'h09);
    chk_all("R2 index low nibble");
    // R8 mirroring, R1 alias through mask
    wr(16'hA000, 8'h01);
    chk_all("R8 mirror horizontal");
    wr(16'hA0FC, 8'hFE);
    chk_all("R1 alias R8 vertical");
    wr(16'h8000, 8'h00); wr(16'h8FFD, 8'h11);
    chk_all("R1 alias bank data");
    // R1 other decoded addresses inert
    wr(16'hC000, 8'h01); wr(16'hC001, 8'hFF); wr(16'hE000, 8'h01);
    wr(16'hE001, 8'h01); wr(16'h8002, 8'h01); wr(16'hA001, 8'h01);
    wr(16'h8001, 8'h77);
    chk_all("R1 ignored writes");
    // R11 unused indices
    for (int i = 10; i <= 14; i++) begin wr(16'h8000, 8'(i)); wr(16'h8001, 8'h5A); end
    chk_all("R11 unused index");
    // R10 truncation and wrap of v+1
    wr(16'h8000, 8'h00); wr(16'h8001, 8'hFF);
    wr(16'h8000, 8'h06); wr(16'h8001, 8'hF3);
    chk_all("R10 bank mask");
    // R9 reset again
    @(negedge clk); rst_n = 0; model_reset();
    @(negedge clk); rst_n = 1;
    chk_all("R9 reset again");
    finished = 1;
    summary();
  end
endmodule